// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Prescaler

This block is a peripheral timer/counter. It holds a 16-bit count that software reaches as two bytes over an 8-bit register bus. The count advances from either the internal instruction-clock enable or an external clock input. That source goes through a prescaler that divides by 1, 2, 4 or 8. When the count passes its top value it wraps to zero and raises a sticky overflow flag. The flag drives an interrupt request through three enables, and it drives a separate wake-up request that does not need the global enable.

The external input can take one of two paths. The first is a two-flop synchroniser with a rising-edge detector. The second is a bypass path that detects edges directly. The system clock keeps running in this model. The `sleeping` input stands for the stopped core clock: the synchronised path freezes, and only the bypass path keeps counting, so only the bypass path can wake the device. A low-power oscillator enable takes over two port pins: their direction bits read as 1 and their data bits read as 0.

The register bus is a plain write strobe with an address. Read data is combinational from the address and never stalls. There is no flow control: every write takes effect in the cycle it is presented.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the count, the control register (address 2) and the status register (address 3) all read 0, and `irq` and `wake` are 0.
- R2: Control bits [5:4] choose the prescale divisor as follows: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The count advances once per that many source pulses.
- R3: A bus write to the low count byte (address 0) or the high count byte (address 1) clears the hidden prescale counter.
- R4: When the count is FFFFh and an increment occurs, the count becomes 0000h and status bit 0 (the overflow flag) is set.
- R5: The overflow flag stays set until software writes 0 to status bit 0. If a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R6: `irq` is 1 exactly when all of these are 1: the flag, status bit 1 (timer interrupt enable), `periph_ie` and `glb_ie`.
- R7: `wake` is 1 when all of these are 1: `sleeping`, the flag, control bit 0 (timer on), status bit 1 and `periph_ie`. `glb_ie` has no effect on `wake`.
- R8: The count advances only while control bit 0 is 1. Control bit 1 selects the source: 0 selects `inst_tick` (ignored while sleeping) and 1 selects `ext_clk`.
- R9: With control bit 2 at 0, each rising edge of `ext_clk` gives one increment after a two-flop synchroniser. The path is frozen while `sleeping` is 1.
- R10: With control bit 2 at 1, each rising edge of `ext_clk` gives one increment, including while sleeping. Changing bit 2 while the timer runs may lose or add one increment.
- R11: With control bit 3 at 1, `pin_dir_rd` reads 2'b11 and `pin_dat_rd` reads 2'b00. With control bit 3 at 0 both pass `pin_dir_in` and `pin_dat_in` through unchanged.
- R12: A write to a count byte in the same cycle as an increment wins over the increment, and the other count byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| inst_tick | input | 1 | Internal instruction-clock enable pulse |
| ext_clk | input | 1 | External count clock |
| sleeping | input | 1 | Core clock stopped |
| periph_ie | input | 1 | Peripheral-group interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| pin_dir_in | input | 2 | Direction bits of the two oscillator pins |
| pin_dat_in | input | 2 | Data bits of the two oscillator pins |
| pin_dir_rd | output | 2 | Direction bits as read back |
| pin_dat_rd | output | 2 | Data bits as read back |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The assertions assume three things about the inputs. First, `sleeping` alone marks the stopped core clock, and the synchroniser flops must hold their values while it is 1. Second, each bus write occupies one cycle with a stable address and data. Third, `ext_clk` changes only at clock boundaries, so each rising edge is seen exactly once. The bench meets these assumptions by driving every input on the falling clock edge. It holds each level of `ext_clk` for several cycles, well above the synchroniser latency. It also drops `inst_tick` before any counting read, so that expected counts are exact, except across a change of synchroniser mode where a difference of one is allowed.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 2;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

  typedef struct packed {
    logic [SEL_W-1:0] div_sel;
    logic             osc_en;
    logic             no_sync;
    logic             src_ext;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic core_run,
  input  logic bypass,
  input  logic ext_in,
  output logic pulse
);
  logic [2:0] sq;
  logic       a_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= '0;
    end else if (core_run) begin
      sq <= {sq[1:0], ext_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_prev <= 1'b0;
    else        a_prev <= ext_in;
  end

  always_comb begin
    if (bypass) pulse = ext_in & ~a_prev;
    else        pulse = core_run & sq[1] & ~sq[2];
  end

  // R9
  sync_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |=> $stable(sq));

  // R10
  bypass_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && pulse) |=> a_prev);
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             pulse_in,
  output logic             tick_out
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] pre;
  logic [PW-1:0] mask;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick_out = pulse_in & ((pre & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre <= '0;
    else if (clr)      pre <= '0;
    else if (pulse_in) pre <= pre + 1'b1;
  end

  // R3
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre == '0));
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          inc,
  output logic [2*DW-1:0] cnt,
  output logic          wrap
);
  localparam int W = 2 * DW;

  logic wr_any;
  assign wr_any = wr_lo | wr_hi;
  assign wrap   = inc & ~wr_any & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_any) begin
      if (wr_lo) cnt[DW-1:0] <= wdata;
      if (wr_hi) cnt[W-1:DW] <= wdata;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R12
  wr_lo_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (cnt[DW-1:0] == $past(wdata)) && (cnt[W-1:DW] == $past(cnt[W-1:DW])));
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              inst_tick,
  input  logic              ext_clk,
  input  logic              sleeping,
  input  logic              periph_ie,
  input  logic              glb_ie,
  input  logic [1:0]        pin_dir_in,
  input  logic [1:0]        pin_dat_in,
  output logic [1:0]        pin_dir_rd,
  output logic [1:0]        pin_dat_rd,
  output logic              irq,
  output logic              wake
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t              ctrl;
  logic               tmr_ie;
  logic               ovf_flag;
  logic [2*DATA_W-1:0] cnt;
  logic               wr_lo, wr_hi, wr_ctrl, wr_stat;
  logic               ext_pulse, src_pulse, pre_tick, wrap;

  assign wr_lo   = bus_we && (bus_addr == A_CNT_LO);
  assign wr_hi   = bus_we && (bus_addr == A_CNT_HI);
  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_stat = bus_we && (bus_addr == A_STAT);

  tmr16_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_run (~sleeping),
    .bypass   (ctrl.no_sync),
    .ext_in   (ext_clk),
    .pulse    (ext_pulse)
  );

  assign src_pulse = ctrl.run & (ctrl.src_ext ? ext_pulse : (inst_tick & ~sleeping));

  tmr16_presc #(.SEL_W(SEL_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr_lo | wr_hi),
    .sel      (ctrl.div_sel),
    .pulse_in (src_pulse),
    .tick_out (pre_tick)
  );

  tmr16_count #(.DW(DATA_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (bus_wdata),
    .inc   (pre_tick),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_ie   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_stat) tmr_ie <= bus_wdata[1];
      if (wrap)         ovf_flag <= 1'b1;
      else if (wr_stat) ovf_flag <= bus_wdata[0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
      A_CNT_HI: bus_rdata = cnt[2*DATA_W-1:DATA_W];
      A_CTRL:   bus_rdata = DATA_W'(ctrl);
      default:  bus_rdata = {{(DATA_W-2){1'b0}}, tmr_ie, ovf_flag};
    endcase
  end

  assign pin_dir_rd = ctrl.osc_en ? 2'b11 : pin_dir_in;
  assign pin_dat_rd = ctrl.osc_en ? 2'b00 : pin_dat_in;

  assign irq  = ovf_flag & tmr_ie & periph_ie & glb_ie;
  assign wake = sleeping & ovf_flag & ctrl.run & tmr_ie & periph_ie;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !wr_stat) |=> ovf_flag);

  // R5
  flag_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: tb/tmr16_unit_test.sv
`timescale 1ns/1ps
module tmr16_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       inst_tick = 1'b0, ext_clk = 1'b0, sleeping = 1'b0;
  logic       periph_ie = 1'b0, glb_ie = 1'b0;
  logic [1:0] pin_dir_in = 2'b00, pin_dat_in = 2'b11;
  logic [1:0] pin_dir_rd, pin_dat_rd;
  logic       irq, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr16_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inst_tick(inst_tick),
    .ext_clk(ext_clk), .sleeping(sleeping), .periph_ie(periph_ie),
    .glb_ie(glb_ie), .pin_dir_in(pin_dir_in), .pin_dat_in(pin_dat_in),
    .pin_dir_rd(pin_dir_rd), .pin_dat_rd(pin_dat_rd), .irq(irq), .wake(wake)
  );

  // vector: {div_sel[1:0], ticks[7:0], expected[15:0]}  (R2)
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'd10, 16'd10}, {2'd1, 8'd10, 16'd5}, {2'd2, 8'd10, 16'd2},
    {2'd3, 8'd10, 16'd1},  {2'd3, 8'd16, 16'd2}, {2'd1, 8'd7,  16'd3}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = int'({hi, lo});
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    inst_tick = 1'b1;
    repeat (n) @(negedge clk);
    inst_tick = 1'b0;
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] b;
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd16(v); chk("R1 count", v, 0);
    rd(2'd2, b); chk("R1 ctrl", b, 0);
    rd(2'd3, b); chk("R1 status", b, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);

    // R2 prescale vector table
    for (int i = 0; i < NV; i++) begin
      set_cnt(16'h0000);
      wr(2'd2, {2'b00, VEC[i][25:24], 4'b0001});
      ticks(int'(VEC[i][23:16]));
      wr(2'd2, 8'h00);
      rd16(v); chk("R2 prescale", v, int'(VEC[i][15:0]));
    end

    // R8 timer off: ticks ignored
    set_cnt(16'h0005);
    ticks(6);
    rd16(v); chk("R8 off holds", v, 5);

    // R3 count write clears prescaler
    set_cnt(16'h0000);
    wr(2'd2, 8'h31);
    ticks(5);
    set_cnt(16'h0000);
    ticks(3);
    wr(2'd2, 8'h00);
    rd16(v); chk("R3 presc cleared", v, 0);

    // R4 wrap and flag
    set_cnt(16'hFFFF);
    wr(2'd2, 8'h01);
    ticks(1);
    rd16(v); chk("R4 wrap", v, 0);
    rd(2'd3, b); chk("R4 flag", b[0], 1);

    // R6 irq gating
    wr(2'd3, 8'h03);
    periph_ie = 1'b1; glb_ie = 1'b0; #1;
    chk("R6 irq no glb", irq, 0);
    glb_ie = 1'b1; #1;
    chk("R6 irq all", irq, 1);
    // R5 software clear
    wr(2'd3, 8'h02);
    chk("R5 sw clear irq", irq, 0);
    rd(2'd3, b); chk("R5 sw clear", b[0], 0);

    // R5 hardware set beats software clear
    wr(2'd2, 8'h00);
    set_cnt(16'hFFFF);
    wr(2'd2, 8'h01);
    @(negedge clk);
    inst_tick = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h02;
    @(negedge clk);
    inst_tick = 1'b0; bus_we = 1'b0;
    rd(2'd3, b); chk("R5 hw wins", b[0], 1);
    wr(2'd3, 8'h02);

    // R12 write beats increment
    wr(2'd2, 8'h00);
    set_cnt(16'h1200);
    wr(2'd2, 8'h01);
    @(negedge clk);
    inst_tick = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h40;
    @(negedge clk);
    inst_tick = 1'b0; bus_we = 1'b0;
    rd16(v); chk("R12 write priority", v, 16'h1240);

    // R9 synchronized external counting
    wr(2'd2, 8'h00);
    set_cnt(16'h0000);
    wr(2'd2, 8'h03);
    ext_edges(5);
    rd16(v); chk("R9 sync edges", v, 5);
    // R9 frozen while sleeping
    sleeping = 1'b1;
    ext_edges(3);
    sleeping = 1'b0;
    repeat (4) @(negedge clk);
    rd16(v); chk("R9 sleep frozen", v, 5);
    // R8 internal tick ignored while sleeping
    wr(2'd2, 8'h01);
    sleeping = 1'b1;
    ticks(4);
    sleeping = 1'b0;
    rd16(v); chk("R8 tick sleep", v, 5);

    // R10 bypass counting during sleep
    wr(2'd2, 8'h07);
    sleeping = 1'b1;
    ext_edges(4);
    sleeping = 1'b0;
    rd16(v); chk("R10 async sleep", v, 9);

    // R10 mode switch tolerance
    set_cnt(16'h0000);
    wr(2'd2, 8'h03);
    ext_edges(5);
    wr(2'd2, 8'h07);
    ext_edges(5);
    wr(2'd2, 8'h00);
    rd16(v);
    n_chk++;
    if (v < 9 || v > 11) begin
      n_bad++;
      $display("FAIL R10 switch: got %0d expected 10 +/- 1", v);
    end

    // R7 wake without global enable
    set_cnt(16'hFFFF);
    wr(2'd3, 8'h02);
    glb_ie = 1'b0; periph_ie = 1'b1;
    wr(2'd2, 8'h07);
    sleeping = 1'b1;
    ext_clk = 1'b1;
    @(negedge clk);
    chk("R7 wake", wake, 1);
    chk("R7 irq off", irq, 0);
    periph_ie = 1'b0; #1;
    chk("R7 wake periph", wake, 0);
    ext_clk = 1'b0;
    sleeping = 1'b0;
    @(negedge clk);

    // R11 pin override
    wr(2'd2, 8'h00);
    chk("R11 dir pass", pin_dir_rd, 0);
    chk("R11 dat pass", pin_dat_rd, 3);
    wr(2'd2, 8'h08);
    chk("R11 dir forced", pin_dir_rd, 3);
    chk("R11 dat forced", pin_dat_rd, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule